// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into the stream of column addresses that a synchronous DRAM burst touches. When a start strobe arrives it captures a starting column, a burst-length code, an ordering bit, a write-burst-mode bit and a read/write flag. From the next clock on it issues one column address per cycle, with a valid flag and a last flag.

Fixed-length bursts of 1, 2, 4 or 8 stay inside the aligned block of that size that holds the starting column. The low bits either count upward and wrap at the block edge (sequential order) or are the start offset XOR a running count (interleaved order). A full-row burst walks every column of the row from the start point, wrapping past the top, until a stop request ends it. A new start can be issued on any cycle and replaces whatever burst is running. Illegal settings still give one access, marked with an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: Length code 3'b000 gives 1 access, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full-row burst. The first address appears in the cycle after the edge that samples start_i.
- R2: With interleave_i=0, access k of an N-long burst is the block base (start column with its low log2(N) bits cleared) plus ((start offset + k) mod N). Example: N=4, offset 2 gives offsets 2,3,0,1.
- R3: With interleave_i=1, access k is the block base plus (start offset XOR k). Example: N=8, offset 5 gives 5,4,7,6,1,0,3,2.
- R4: A full-row burst (code 3'b111, interleave_i=0) steps the column by one each cycle, wrapping from 511 to 0, and keeps going with last_o low until stop_i is raised.
- R5: For a length of 1 the interleave_i input has no effect on the address.
- R6: When is_write_i=1 and single_write_i=1, the burst is a single access whatever the length code. Reads ignore single_write_i.
- R7: A start_i on any cycle, including during a running burst, begins the new burst on the next cycle. The old burst issues no more addresses.
- R8: A length code of 3'b100, 3'b101 or 3'b110, or code 3'b111 with interleave_i=1, gives exactly one access at the start column with cfg_err_o=1 and last_o=1. cfg_err_o is 0 on every other access.
- R9: last_o is 1 on the final access of a fixed-length burst, and also in any cycle where valid_o=1 and stop_i=1. After a cycle with last_o=1 and no start_i, valid_o is 0.
- R10: After reset, valid_o, last_o and cfg_err_o are 0.
- R11: stop_i while no burst is running has no effect: valid_o and last_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst with the settings below |
| is_write_i | input | 1 | 1 for a write command, 0 for a read |
| start_col_i | input | COL_W (9) | Starting column |
| len_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 0 sequential order, 1 interleaved order |
| single_write_i | input | 1 | 1 forces writes to one access |
| stop_i | input | 1 | End the running burst after the current access |
| col_o | output | COL_W (9) | Column address of the current access |
| valid_o | output | 1 | col_o holds an access this cycle |
| last_o | output | 1 | Current access is the final one of its burst |
| cfg_err_o | output | 1 | Current access came from an illegal setting |

## Verification
The assertions assume the control inputs are known, two-valued levels at each rising edge once reset is released, and that stop_i may be high in any cycle, busy or not. The step and block checks assume that start_i marks a burst boundary: the settings it carries are captured only at that edge, so the properties never compare an address against a burst that a new start has replaced. The bench changes every input only at falling edges and holds start_i high for one cycle per command, except in the back-to-back case, where it is held high over several edges on purpose.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int COL_BITS = 9;
  localparam int CODE_BITS = 3;
  localparam int LG_W = 4;

  localparam logic [CODE_BITS-1:0] LEN_ONE   = 3'b000;
  localparam logic [CODE_BITS-1:0] LEN_TWO   = 3'b001;
  localparam logic [CODE_BITS-1:0] LEN_FOUR  = 3'b010;
  localparam logic [CODE_BITS-1:0] LEN_EIGHT = 3'b011;
  localparam logic [CODE_BITS-1:0] LEN_ROW   = 3'b111;

  typedef struct packed {
    logic            full;
    logic            err;
    logic [LG_W-1:0] lg;
  } burst_cfg_t;

  // Map a length code, ordering and single-write force onto a burst shape.
  function automatic burst_cfg_t decode_len(input logic [CODE_BITS-1:0] code,
                                            input logic ilv,
                                            input logic force_one);
    burst_cfg_t c;
    c = '0;
    case (code)
      LEN_ONE:   c.lg = 4'd0;
      LEN_TWO:   c.lg = 4'd1;
      LEN_FOUR:  c.lg = 4'd2;
      LEN_EIGHT: c.lg = 4'd3;
      LEN_ROW: begin
        if (ilv) c.err = 1'b1;
        else     c.full = 1'b1;
      end
      default:   c.err = 1'b1;
    endcase
    if (force_one) begin
      c.full = 1'b0;
      c.lg   = 4'd0;
    end
    return c;
  endfunction

endpackage

// File: rtl/blen_decode.sv
module blen_decode #(
  parameter int COL_W  = bcg_pkg::COL_BITS,
  parameter int CODE_W = bcg_pkg::CODE_BITS
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              ilv_i,
  input  logic              is_write_i,
  input  logic              single_write_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o,
  output logic              err_o
);
  import bcg_pkg::*;

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  burst_cfg_t cfg_w;
  logic       force_one_w;

  assign force_one_w = is_write_i & single_write_i;
  assign cfg_w       = decode_len(code_i, ilv_i, force_one_w);

  // Block mask: all ones across a row, else N-1 for a burst of N.
  always_comb begin
    if (cfg_w.full) mask_o = '1;
    else            mask_o = (ONE << cfg_w.lg) - ONE;
  end

  assign full_o = cfg_w.full;
  assign err_o  = cfg_w.err;

endmodule

// File: rtl/col_step.sv
module col_step #(
  parameter int COL_W = bcg_pkg::COL_BITS
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);

  // Keep the block bits of the base; the low bits follow the chosen order.
  function automatic logic [COL_W-1:0] step_addr(input logic [COL_W-1:0] base,
                                                 input logic [COL_W-1:0] mask,
                                                 input logic [COL_W-1:0] cnt,
                                                 input logic ilv);
    logic [COL_W-1:0] off;
    logic [COL_W-1:0] lo;
    off = base & mask;
    if (ilv) lo = off ^ cnt;
    else     lo = off + cnt;
    return (base & ~mask) | (lo & mask);
  endfunction

  assign addr_o = step_addr(base_i, mask_i, cnt_i, ilv_i);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = bcg_pkg::COL_BITS,
  parameter int CODE_W = bcg_pkg::CODE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              interleave_i,
  input  logic              single_write_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              cfg_err_o
);

  logic [COL_W-1:0] dec_mask_w;
  logic             dec_full_w;
  logic             dec_err_w;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] cnt_q;
  logic             ilv_q;
  logic             full_q;
  logic             err_q;
  logic             valid_q;

  logic             at_end_w;
  logic             stop_take_w;
  logic             burst_done_w;

  blen_decode #(.COL_W(COL_W), .CODE_W(CODE_W)) u_dec (
    .code_i         (len_code_i),
    .ilv_i          (interleave_i),
    .is_write_i     (is_write_i),
    .single_write_i (single_write_i),
    .mask_o         (dec_mask_w),
    .full_o         (dec_full_w),
    .err_o          (dec_err_w)
  );

  col_step #(.COL_W(COL_W)) u_step (
    .base_i (base_q),
    .mask_i (mask_q),
    .cnt_i  (cnt_q),
    .ilv_i  (ilv_q),
    .addr_o (col_o)
  );

  assign at_end_w     = ~full_q & (cnt_q == mask_q);
  assign stop_take_w  = valid_q & stop_i;
  assign burst_done_w = valid_q & (at_end_w | stop_take_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      mask_q  <= dec_mask_w;
      cnt_q   <= '0;
      ilv_q   <= interleave_i;
      full_q  <= dec_full_w;
      err_q   <= dec_err_w;
      valid_q <= 1'b1;
    end else if (valid_q) begin
      if (burst_done_w) begin
        valid_q <= 1'b0;
        err_q   <= 1'b0;
        full_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + COL_W'(1);
      end
    end
  end

  assign valid_o   = valid_q;
  assign last_o    = burst_done_w;
  assign cfg_err_o = valid_q & err_q;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = bcg_pkg::COL_BITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             cfg_err_o,
  input logic [COL_W-1:0] blk_mask,
  input logic             full_page
);

  // R7
  start_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  // R9
  last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o && !start_i) |=> !valid_o);

  // R9
  burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i) |=> valid_o);

  // R9
  stop_marks_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stop_i) |-> last_o);

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (valid_o && last_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> (!valid_o && !last_o));

  // R2
  block_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i) |=>
      ((col_o & ~$past(blk_mask)) == ($past(col_o) & ~$past(blk_mask))));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_page && !last_o && !start_i) |=>
      (col_o == $past(col_o) + COL_W'(1)));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .col_o     (col_o),
  .valid_o   (valid_o),
  .last_o    (last_o),
  .cfg_err_o (cfg_err_o),
  .blk_mask  (mask_q),
  .full_page (full_q)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int CLK_P = 10;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             is_write_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = 3'b000;
  logic             interleave_i = 1'b0;
  logic             single_write_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             cfg_err_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .is_write_i     (is_write_i),
    .start_col_i    (start_col_i),
    .len_code_i     (len_code_i),
    .interleave_i   (interleave_i),
    .single_write_i (single_write_i),
    .stop_i         (stop_i),
    .col_o          (col_o),
    .valid_o        (valid_o),
    .last_o         (last_o),
    .cfg_err_o      (cfg_err_o)
  );

  // Expected column of access k, from block arithmetic.
  function automatic int exp_col(int start, int n, bit ilv, int k);
    int blk;
    int off;
    blk = (start / n) * n;
    off = start % n;
    if (ilv) return blk + (off ^ k);
    return blk + ((off + k) % n);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(int col, int code, bit ilv, bit wr, bit sw);
    @(negedge clk);
    start_i        = 1'b1;
    start_col_i    = COL_W'(col);
    len_code_i     = 3'(code);
    interleave_i   = ilv;
    is_write_i     = wr;
    single_write_i = sw;
    @(negedge clk);
    start_i = 1'b0;
    #1;
  endtask

  // Issue one command and follow the whole burst; n = expected accesses.
  task automatic run_burst(string req, int col, int code, bit ilv, bit wr,
                           bit sw, int n, int blk_n, bit err);
    issue(col, code, ilv, wr, sw);
    for (int k = 0; k < n; k++) begin
      check(valid_o == 1'b1, req, "valid", int'(valid_o), 1);
      check(int'(col_o) == exp_col(col, blk_n, ilv, k), req, "column",
            int'(col_o), exp_col(col, blk_n, ilv, k));
      check(last_o == (k == n - 1), req, "last", int'(last_o), int'(k == n - 1));
      check(cfg_err_o == err, req, "error flag", int'(cfg_err_o), int'(err));
      @(negedge clk);
      #1;
    end
    check(valid_o == 1'b0, req, "valid after burst", int'(valid_o), 0);
  endtask

  task automatic t_reset();
    #1;
    check(valid_o == 1'b0, "R10", "valid in reset", int'(valid_o), 0);
    check(last_o == 1'b0, "R10", "last in reset", int'(last_o), 0);
    check(cfg_err_o == 1'b0, "R10", "err in reset", int'(cfg_err_o), 0);
  endtask

  task automatic t_lengths();
    // R1 each code
    run_burst("R1", 37, 0, 1'b0, 1'b0, 1'b0, 1, 1, 1'b0);
    run_burst("R1", 37, 1, 1'b0, 1'b0, 1'b0, 2, 2, 1'b0);
    run_burst("R1", 37, 2, 1'b0, 1'b0, 1'b0, 4, 4, 1'b0);
    run_burst("R1", 37, 3, 1'b0, 1'b0, 1'b0, 8, 8, 1'b0);
  endtask

  task automatic t_sequential();
    // R2: offset 2 in block of four, and high block bits kept
    run_burst("R2", 6, 2, 1'b0, 1'b0, 1'b0, 4, 4, 1'b0);
    run_burst("R2", 502, 3, 1'b0, 1'b0, 1'b0, 8, 8, 1'b0);
    run_burst("R2", 131, 1, 1'b0, 1'b1, 1'b0, 2, 2, 1'b0);
  endtask

  task automatic t_interleaved();
    // R3: offset 5 in block of eight gives 5,4,7,6,1,0,3,2
    run_burst("R3", 77, 3, 1'b1, 1'b0, 1'b0, 8, 8, 1'b0);
    run_burst("R3", 259, 2, 1'b1, 1'b1, 1'b0, 4, 4, 1'b0);
  endtask

  task automatic t_full_row();
    // R4: from 500, wrap past 511, stop at access 600
    issue(500, 7, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 600; k++) begin
      check(valid_o == 1'b1 && last_o == 1'b0, "R4", "running",
            int'({valid_o, last_o}), 2);
      check(int'(col_o) == (500 + k) % 512, "R4", "column", int'(col_o),
            (500 + k) % 512);
      @(negedge clk);
      #1;
    end
    stop_i = 1'b1;
    #1;
    check(last_o == 1'b1, "R9", "last on stop", int'(last_o), 1);
    check(int'(col_o) == (500 + 600) % 512, "R4", "column at stop",
          int'(col_o), (500 + 600) % 512);
    @(negedge clk);
    stop_i = 1'b0;
    #1;
    check(valid_o == 1'b0, "R9", "valid after stop", int'(valid_o), 0);
  endtask

  task automatic t_len_one();
    // R5: interleave has no effect on a single access
    run_burst("R5", 301, 0, 1'b1, 1'b0, 1'b0, 1, 1, 1'b0);
    run_burst("R5", 300, 0, 1'b1, 1'b1, 1'b0, 1, 1, 1'b0);
  endtask

  task automatic t_single_write();
    // R6
    run_burst("R6", 21, 3, 1'b0, 1'b1, 1'b1, 1, 1, 1'b0);
    run_burst("R6", 400, 7, 1'b0, 1'b1, 1'b1, 1, 1, 1'b0);
    run_burst("R6", 21, 3, 1'b0, 1'b0, 1'b1, 8, 8, 1'b0);
  endtask

  task automatic t_preempt();
    // R7: burst of eight from 8, replaced after three accesses
    issue(8, 3, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check(int'(col_o) == 8 + k, "R7", "first burst", int'(col_o), 8 + k);
      @(negedge clk);
      #1;
    end
    start_i = 1'b1; start_col_i = 9'd17; len_code_i = 3'b010; interleave_i = 1'b1;
    #1;
    check(int'(col_o) == 11 && last_o == 1'b0, "R7", "access before switch",
          int'(col_o), 11);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    for (int k = 0; k < 4; k++) begin
      check(int'(col_o) == exp_col(17, 4, 1'b1, k), "R7", "new burst",
            int'(col_o), exp_col(17, 4, 1'b1, k));
      check(last_o == (k == 3), "R7", "new burst last", int'(last_o), int'(k == 3));
      @(negedge clk);
      #1;
    end
    check(valid_o == 1'b0, "R7", "idle after new burst", int'(valid_o), 0);
    // R7: one new column per clock
    @(negedge clk);
    start_i = 1'b1; len_code_i = 3'b000; interleave_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      start_col_i = COL_W'(90 + 7 * k);
      @(negedge clk);
      #1;
      check(valid_o && last_o && int'(col_o) == 90 + 7 * k, "R7", "back to back",
            int'(col_o), 90 + 7 * k);
    end
    start_i = 1'b0;
    @(negedge clk);
    #1;
    check(valid_o == 1'b0, "R7", "idle after stream", int'(valid_o), 0);
  endtask

  task automatic t_errors();
    // R8: reserved codes and interleaved full row
    run_burst("R8", 45, 4, 1'b0, 1'b0, 1'b0, 1, 1, 1'b1);
    run_burst("R8", 46, 5, 1'b1, 1'b1, 1'b0, 1, 1, 1'b1);
    run_burst("R8", 47, 6, 1'b0, 1'b0, 1'b0, 1, 1, 1'b1);
    run_burst("R8", 211, 7, 1'b1, 1'b0, 1'b0, 1, 1, 1'b1);
  endtask

  task automatic t_stop();
    // R9: stop during a fixed burst of eight at access 2
    issue(64, 3, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 2; k++) begin
      check(last_o == 1'b0, "R9", "not last yet", int'(last_o), 0);
      @(negedge clk);
      #1;
    end
    stop_i = 1'b1;
    #1;
    check(last_o == 1'b1 && int'(col_o) == 66, "R9", "last on stop", int'(col_o), 66);
    @(negedge clk);
    stop_i = 1'b0;
    #1;
    check(valid_o == 1'b0, "R9", "ended by stop", int'(valid_o), 0);
    // R11: stop while idle
    stop_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(valid_o == 1'b0 && last_o == 1'b0, "R11", "idle stop",
            int'({valid_o, last_o}), 0);
    end
    stop_i = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_lengths();
    t_sequential();
    t_interleaved();
    t_full_row();
    t_len_one();
    t_single_write();
    t_preempt();
    t_errors();
    t_stop();
    report();
    $finish;
  end

endmodule